// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Line Break

The block turns bytes handed over by a host into asynchronous serial frames on one output line. A one-byte holding register takes host writes; whenever the internal shifter is free, the held byte moves across on its own. A second byte can therefore be queued while the first is still on the line, and the two frames follow each other with no idle gap.

Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, then a high stop period of one, one and a half or two bit times. All bit timing comes from a 16x tick enable supplied from outside; the divisor that makes that tick lies outside this block. Two status outputs report an empty holding register and a fully idle transmitter. A break input pulls the line low for as long as it is held, without stopping the frame in progress.

Top module: `ser_tx_top`

## Requirements
- R1: A written byte moves from the holding register into the shifter on the first clock edge at which the shifter is idle. Its start bit appears on the line one clock after that edge. A byte queued during a frame begins its start bit on the same edge that ends the previous stop period.
- R2: `holdEmpty` is 1 after reset. It is 0 from the clock after a host write. It returns to 1 on the clock after the byte moves into the shifter.
- R3: `txEmpty` is 1 after reset. It is 1 only when the holding register is empty and the shifter is idle.
- R4: A frame has one start bit at 0, then N data bits taken from `wrData` bit 0 upwards. N = 5 + `wordLen`, so codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits.
- R5: With `parityEn`=1, one parity bit follows the data bits. It is computed over the N configured bits only. With `parityOdd`=1, the data ones plus the parity bit give an odd count; with `parityOdd`=0 they give an even count.
- R6: The stop period is driven as 1. With `longStop`=0 it lasts 16 ticks. With `longStop`=1 it lasts 32 ticks, or 24 ticks when `wordLen`=0.
- R7: With no frame in progress and `breakEn`=0, `txOut` is 1.
- R8: While `breakEn`=1, `txOut` is 0 in every state, including idle. `txOut` follows the frame again once `breakEn` returns to 0.
- R9: Break does not stall the frame. Bits after a break ends appear at the times they would have had with no break.
- R10: Start, data and parity bits each last 16 ticks. Clock cycles without `tickEn` do not advance a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Oversampling tick, 16 per bit time |
| wrEn | input | 1 | Host write strobe for the holding register |
| wrData | input | 8 | Byte to send |
| wordLen | input | 2 | Data length code, 5 + code bits |
| parityEn | input | 1 | Insert a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| longStop | input | 1 | Long stop period (2 bits, or 1.5 bits for 5-bit words) |
| breakEn | input | 1 | Force the line low |
| txOut | output | 1 | Serial line |
| holdEmpty | output | 1 | Holding register empty |
| txEmpty | output | 1 | Holding register and shifter both empty |

## Verification
A write is seen on `holdEmpty` one clock later. With an idle shifter, the start bit and the return of `holdEmpty` follow one clock after that, so the bench checks both status flags at the falling edge between those clocks. With a tick on every cycle, bit k of a frame is centred 16k+8 cycles after the start bit falls, and the bench samples each bit at exactly that cycle. A second byte queued behind the first pins the stop length to the cycle: the last stop cycle must be high and the very next cycle low. The slow-tick and break cases are checked with windows derived from the tick spacing rather than from fixed cycle counts.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } txState_t;

  typedef enum logic [1:0] {
    LN_MARK, LN_SPACE, LN_DATA, LN_PARITY
  } lineSel_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_t lineSel;
  } txStrobe_t;
endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 8,
  parameter int LEN_W         = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             holdValid,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             parityEn,
  input  logic             longStop,
  output txStrobe_t        strobe,
  output logic             busy
);
  localparam int TICK_W = $clog2(2 * TICKS_PER_BIT);
  localparam int BIT_W  = $clog2(MAX_BITS);
  localparam logic [TICK_W-1:0] BIT_LAST   = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [TICK_W-1:0] STOP1_LAST = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [TICK_W-1:0] STOP15_LAST = TICK_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [TICK_W-1:0] STOP2_LAST = TICK_W'(2 * TICKS_PER_BIT - 1);

  txState_t          state;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  lastBitQ;
  logic              parEnQ;
  logic [TICK_W-1:0] stopLastQ;
  logic [TICK_W-1:0] stopLastNew;
  logic [BIT_W-1:0]  lastBitNew;
  logic              bitEnd;
  logic              stopEnd;
  logic              loadNow;

  always_comb begin
    lastBitNew = BIT_W'(MIN_BITS - 1) + BIT_W'(wordLen);
    if (!longStop)          stopLastNew = STOP1_LAST;
    else if (wordLen == '0) stopLastNew = STOP15_LAST;
    else                    stopLastNew = STOP2_LAST;
  end

  assign bitEnd  = tickEn && (tickCnt == BIT_LAST);
  assign stopEnd = tickEn && (state == ST_STOP) && (tickCnt == stopLastQ);
  assign loadNow = holdValid && ((state == ST_IDLE) || stopEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitCnt    <= '0;
      lastBitQ  <= '0;
      parEnQ    <= 1'b0;
      stopLastQ <= STOP1_LAST;
    end else if (loadNow) begin
      state     <= ST_START;
      tickCnt   <= '0;
      bitCnt    <= '0;
      lastBitQ  <= lastBitNew;
      parEnQ    <= parityEn;
      stopLastQ <= stopLastNew;
    end else if (tickEn) begin
      case (state)
        ST_START: begin
          if (bitEnd) begin
            state   <= ST_DATA;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + 1'b1;
        end
        ST_DATA: begin
          if (bitEnd) begin
            tickCnt <= '0;
            if (bitCnt == lastBitQ) state <= parEnQ ? ST_PARITY : ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end else tickCnt <= tickCnt + 1'b1;
        end
        ST_PARITY: begin
          if (bitEnd) begin
            state   <= ST_STOP;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + 1'b1;
        end
        ST_STOP: begin
          if (tickCnt == stopLastQ) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + 1'b1;
        end
        default: tickCnt <= '0;
      endcase
    end
  end

  always_comb begin
    strobe.load  = loadNow;
    strobe.shift = (state == ST_DATA) && bitEnd && (bitCnt != lastBitQ);
    case (state)
      ST_START:  strobe.lineSel = LN_SPACE;
      ST_DATA:   strobe.lineSel = LN_DATA;
      ST_PARITY: strobe.lineSel = LN_PARITY;
      default:   strobe.lineSel = LN_MARK;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitCnt <= lastBitQ));

  // R6
  stop_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |-> (tickCnt <= stopLastQ));
endmodule

// File: rtl/ser_tx_dp.sv
module ser_tx_dp
  import ser_tx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [MAX_BITS-1:0] wrData,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                parityOdd,
  input  txStrobe_t           strobe,
  output logic                holdValid,
  output logic                lineBit
);
  localparam int BIT_W = $clog2(MAX_BITS);

  logic [MAX_BITS-1:0] holdReg;
  logic [MAX_BITS-1:0] shiftReg;
  logic [MAX_BITS-1:0] lenMask;
  logic [BIT_W-1:0]    lastBit;
  logic                parityQ;

  assign lastBit = BIT_W'(MIN_BITS - 1) + BIT_W'(wordLen);

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign lenMask[i] = (BIT_W'(i) <= lastBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else if (wrEn) begin
      holdReg   <= wrData;
      holdValid <= 1'b1;
    end else if (strobe.load) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parityQ  <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= holdReg;
      parityQ  <= (^(holdReg & lenMask)) ^ parityOdd;
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LN_SPACE:  lineBit = 1'b0;
      LN_DATA:   lineBit = shiftReg[0];
      LN_PARITY: lineBit = parityQ;
      default:   lineBit = 1'b1;
    endcase
  end

  // R2
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> holdValid);

  // R1
  load_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> holdValid);
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 8,
  parameter int LEN_W         = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                wrEn,
  input  logic [MAX_BITS-1:0] wrData,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                longStop,
  input  logic                breakEn,
  output logic                txOut,
  output logic                holdEmpty,
  output logic                txEmpty
);
  txStrobe_t strobe;
  logic      holdValid;
  logic      busy;
  logic      lineBit;

  ser_tx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .MAX_BITS     (MAX_BITS),
    .LEN_W        (LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .holdValid(holdValid),
    .wordLen  (wordLen),
    .parityEn (parityEn),
    .longStop (longStop),
    .strobe   (strobe),
    .busy     (busy)
  );

  ser_tx_dp #(
    .MAX_BITS(MAX_BITS),
    .LEN_W   (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .wordLen  (wordLen),
    .parityOdd(parityOdd),
    .strobe   (strobe),
    .holdValid(holdValid),
    .lineBit  (lineBit)
  );

  assign txOut     = breakEn ? 1'b0 : lineBit;
  assign holdEmpty = !holdValid;
  assign txEmpty   = !holdValid && !busy;

  // R8
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakEn |-> !txOut);

  // R7
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!breakEn && txEmpty) |-> txOut);

  // R10
  shift_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> tickEn);
endmodule

// File: tb/sim_ser_tx_top.sv
module sim_ser_tx_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] wordLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       longStop = 1'b0;
  logic       breakEn = 1'b0;
  logic       txOut, holdEmpty, txEmpty;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tickDiv = 1;
  int tickPh = 0;
  bit tickGate = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tickPh + 1 >= tickDiv) tickPh <= 0;
    else tickPh <= tickPh + 1;
    tickEn <= !tickGate && (tickPh + 1 >= tickDiv);
  end

  ser_tx_top u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .wordLen(wordLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .longStop(longStop), .breakEn(breakEn), .txOut(txOut),
    .holdEmpty(holdEmpty), .txEmpty(txEmpty)
  );

  // data, len code, parity enable, odd, long stop
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd2, 1'b1, 1'b0, 1'b0},
    {8'h1D, 2'd0, 1'b1, 1'b1, 1'b1},
    {8'hE3, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h5A, 2'd1, 1'b1, 1'b1, 1'b1},
    {8'hFF, 2'd3, 1'b1, 1'b0, 1'b1},
    {8'h80, 2'd3, 1'b1, 1'b1, 1'b0},
    {8'h01, 2'd2, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic waitCyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic hostWrite(logic [7:0] d);
    wrData = d;
    wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle(string req);
    int n = 0;
    while (!txEmpty && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(req, txEmpty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 R3 R7: reset state
    check("R2 reset holdEmpty", holdEmpty, 1);
    check("R3 reset txEmpty", txEmpty, 1);
    check("R7 reset line", txOut, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 idle line", txOut, 1);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      int n, p, stopT, frameLen, tA;
      logic par;
      logic [7:0] mask;
      d = VEC[v][12:5];
      wordLen = VEC[v][4:3];
      parityEn = VEC[v][2];
      parityOdd = VEC[v][1];
      longStop = VEC[v][0];
      n = 5 + int'(wordLen);
      p = parityEn ? 1 : 0;
      stopT = !longStop ? 16 : (n == 5 ? 24 : 32);
      frameLen = 16 * (1 + n + p) + stopT;
      mask = 8'((1 << n) - 1);
      par = (^(d & mask)) ^ parityOdd;

      hostWrite(d);
      check("R2 holdEmpty after write", holdEmpty, 0);
      check("R3 txEmpty after write", txEmpty, 0);
      @(negedge clk);
      check("R1 start one cycle after load", txOut, 0);
      check("R2 holdEmpty after transfer", holdEmpty, 1);
      tA = cyc;
      hostWrite(~d);
      check("R2 queued byte held", holdEmpty, 0);
      check("R3 busy with queued byte", txEmpty, 0);
      waitCyc(tA + 8);
      check("R4 start bit", txOut, 0);
      for (int k = 0; k < n; k++) begin
        waitCyc(tA + 16 * (1 + k) + 8);
        check("R4 data bit", txOut, int'(d[k]));
      end
      if (p == 1) begin
        waitCyc(tA + 16 * (1 + n) + 8);
        check("R5 parity bit", txOut, int'(par));
      end
      waitCyc(tA + 16 * (1 + n + p) + 8);
      check("R6 stop level", txOut, 1);
      waitCyc(tA + frameLen - 1);
      check("R6 stop last cycle", txOut, 1);
      waitCyc(tA + frameLen);
      check("R1 R6 back-to-back start", txOut, 0);
      check("R2 queued byte transferred", holdEmpty, 1);
      waitIdle("R3 txEmpty after frames");
      check("R7 idle after frames", txOut, 1);
    end

    // R8: break while idle
    wordLen = 2'd3; parityEn = 1'b0; longStop = 1'b0;
    breakEn = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 break forces idle line low", txOut, 0);
    check("R8 break starts nothing", txEmpty, 1);
    breakEn = 1'b0;
    @(negedge clk);
    check("R8 line released", txOut, 1);

    // R9: break over part of a frame of all ones
    begin
      int tB;
      hostWrite(8'hFF);
      @(negedge clk);
      tB = cyc;
      waitCyc(tB + 20);
      breakEn = 1'b1;
      waitCyc(tB + 40);
      check("R8 break during data", txOut, 0);
      waitCyc(tB + 60);
      breakEn = 1'b0;
      waitCyc(tB + 72);
      check("R9 data bit after break", txOut, 1);
      waitCyc(tB + 16 * 9 + 15);
      check("R9 frame still busy before stop end", txEmpty, 0);
      waitCyc(tB + 16 * 9 + 17);
      check("R9 frame ends on schedule", txEmpty, 1);
    end

    // R10: no ticks, no progress
    tickGate = 1'b1;
    repeat (2) @(negedge clk);
    hostWrite(8'hFF);
    @(negedge clk);
    check("R10 start without ticks", txOut, 0);
    repeat (100) @(negedge clk);
    check("R10 frozen without ticks", txOut, 0);
    tickGate = 1'b0;
    waitIdle("R10 frame completes once ticks resume");

    // R10: one tick every 4 cycles, start lasts 16 ticks
    tickDiv = 4;
    repeat (8) @(negedge clk);
    hostWrite(8'hFF);
    @(negedge clk);
    begin
      int low = 0;
      while (txOut == 1'b0 && low < 200) begin
        low++;
        @(negedge clk);
      end
      checks++;
      if (low < 61 || low > 64) begin
        errors++;
        $display("FAIL R10 start length: actual=%0d expected=61..64", low);
      end
    end
    waitIdle("R10 slow frame completes");
    tickDiv = 1;

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule